// File: doc/BRIEF.md
# Multi-Channel Gamma Lookup Loader

This block keeps the gamma correction tables for several display channels and applies them to pixels as they stream past. Every channel owns three tables, one per colour component, each holding 256 eight-bit entries. All tables sit in one linear address space that software fills through a two-register write port. One register holds a pointer and an auto-advance flag. The other register takes table data. A full reload is therefore one pointer write followed by a burst of data writes.

Each channel takes its own stream of valid-qualified RGB pixels. When gamma is switched on for a channel, each component is replaced by its table entry. When gamma is off, the pixel goes through unchanged. Either path takes exactly one clock. When gamma is off on every channel, the table storage is treated as powered down: its contents are wiped and data writes are dropped. Software must reload the tables, usually with an identity ramp, before gamma is turned on again.

Top module: `gamma_lut_loader`

## Requirements
- R1: After reset the pointer is 0 with auto-advance off, and `pix_vld_o` is all zero.
- R2: A write with `reg_sel`=0 loads the pointer from `reg_wdata[11:0]` and the auto-advance flag from `reg_wdata[15]`.
- R3: A write with `reg_sel`=1 stores `reg_wdata[7:0]` at the pointer. Address = channel*768 + colour*256 + index, with colour 0 red, 1 green, 2 blue.
- R4: With auto-advance set, each data write moves the pointer up by one (12-bit wrap). With it clear, the pointer stays and repeated writes overwrite the same entry.
- R5: A data write at a pointer of 2304 or above changes no entry, but it still advances the pointer when auto-advance is set.
- R6: For a channel with gamma on, the output red, green and blue are the channel's red, green and blue table entries indexed by the input components. Pixel packing is red [23:16], green [15:8], blue [7:0], and channel k uses bits [24k+23:24k].
- R7: For a channel with gamma off, the output pixel equals the input pixel.
- R8: Each output pixel and its valid appear exactly one clock after the input is sampled, with no loss or reordering across back-to-back pixels.
- R9: While `gamma_en` is all zero, every entry is cleared to 0 and data writes are ignored. After gamma is turned back on, lookups return 0 until the tables are reloaded.
- R10: A data write changes only the single entry it addresses. Other colours and other channels are untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = pointer register, 1 = table data |
| reg_wdata | input | 16 | Write data |
| gamma_en | input | 3 | Per-channel gamma enable |
| pix_vld_i | input | 3 | Per-channel input pixel valid |
| pix_i | input | 72 | Input pixels, 24 bits per channel |
| pix_vld_o | output | 3 | Per-channel output pixel valid |
| pix_o | output | 72 | Output pixels, 24 bits per channel |

## Verification
The bench loads a full identity ramp, then overwrites one colour of one channel. This exposes a wrong channel or colour stride, which would corrupt a neighbouring table. It probes the last legal entry, the first illegal address, and a pointer wrap from 4095 to 0. A design that wrote out-of-range data into storage, or stopped advancing past the end, would return the wrong value at entry 0. It checks pointer hold without auto-advance, and it power-cycles all enables with a write in between. A design that retained contents, or accepted writes while powered down, would return non-zero values after re-enable. A long burst with irregular valid masks catches latency or ordering slips between the lookup path and the bypass path.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
    parameter int ENT_W = 8;
    localparam int NCOL = 3;
    localparam int REG_W = 16;
    localparam int AUTOINC_BIT = REG_W - 1;
    localparam logic REG_SEL_ADDR = 1'b0;
    localparam logic REG_SEL_DATA = 1'b1;

    typedef enum logic [1:0] {
        COL_RED   = 2'd0,
        COL_GREEN = 2'd1,
        COL_BLUE  = 2'd2
    } colour_e;

    typedef struct packed {
        logic [ENT_W-1:0] red;
        logic [ENT_W-1:0] green;
        logic [ENT_W-1:0] blue;
    } pixel_t;

    localparam int PIX_W = $bits(pixel_t);
endpackage

// File: rtl/gamma_addr_ctrl.sv
module gamma_addr_ctrl
    import gamma_lut_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int LUT_DEPTH = 256,
    parameter int TOTAL     = NUM_CH * NCOL * LUT_DEPTH,
    parameter int ADDR_W    = $clog2(TOTAL + 1),
    parameter int IDX_W     = $clog2(LUT_DEPTH),
    parameter int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              pwr_dn,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic              wr_valid_o,
    output logic [CH_W-1:0]   wr_ch_o,
    output colour_e           wr_col_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [ENT_W-1:0]  wr_data_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              autoinc;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic [ADDR_W-1:0] blk;
    logic in_range;
    logic data_wr;

    always_comb begin
        ctrl_d  = ctrl_q;
        data_wr = reg_we && (reg_sel == REG_SEL_DATA);
        if (reg_we && (reg_sel == REG_SEL_ADDR)) begin
            ctrl_d.addr    = reg_wdata[ADDR_W-1:0];
            ctrl_d.autoinc = reg_wdata[AUTOINC_BIT];
        end else if (data_wr && ctrl_q.autoinc) begin
            ctrl_d.addr = ctrl_q.addr + 1'b1;
        end
        blk        = ctrl_q.addr >> IDX_W;
        in_range   = ctrl_q.addr < ADDR_W'(TOTAL);
        wr_valid_o = data_wr && in_range && !pwr_dn;
        wr_ch_o    = CH_W'(blk / ADDR_W'(NCOL));
        wr_col_o   = colour_e'(2'(blk % ADDR_W'(NCOL)));
        wr_idx_o   = ctrl_q.addr[IDX_W-1:0];
        wr_data_o  = reg_wdata[ENT_W-1:0];
        cur_addr_o = ctrl_q.addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == REG_SEL_ADDR) |=> (cur_addr_o == $past(reg_wdata[ADDR_W-1:0]))); // R2
    AST_AUTOINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == REG_SEL_DATA && ctrl_q.autoinc) |=> (cur_addr_o == ADDR_W'($past(cur_addr_o) + 1'b1))); // R4
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == REG_SEL_DATA && !ctrl_q.autoinc) |=> $stable(cur_addr_o)); // R4
endmodule

// File: rtl/gamma_bank.sv
module gamma_bank #(
    parameter int DEPTH = 256,
    parameter int W     = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [W-1:0]     wdat,
    input  logic [IDX_W-1:0] ridx,
    output logic [W-1:0]     rdat
);
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] rdat_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wdat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdat_q <= '0;
        else        rdat_q <= mem[ridx];
    end

    assign rdat = rdat_q;
endmodule

// File: rtl/gamma_lane.sv
module gamma_lane
    import gamma_lut_pkg::*;
#(
    parameter int LUT_DEPTH = 256,
    parameter int IDX_W     = $clog2(LUT_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_dn,
    input  logic             en,
    input  logic [NCOL-1:0]  bank_we,
    input  logic [IDX_W-1:0] widx,
    input  logic [ENT_W-1:0] wdat,
    input  logic             vld_i,
    input  pixel_t           pix_i,
    output logic             vld_o,
    output pixel_t           pix_o
);
    typedef struct packed {
        logic   vld;
        logic   en;
        pixel_t pix;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    logic [NCOL-1:0][ENT_W-1:0] comp_in;
    logic [NCOL-1:0][ENT_W-1:0] comp_lut;
    logic past_ok_q;

    assign comp_in = pix_i;

    for (genvar k = 0; k < NCOL; k++) begin : g_col
        logic [ENT_W-1:0] rd;
        gamma_bank #(.DEPTH(LUT_DEPTH), .W(ENT_W), .IDX_W(IDX_W)) u_bank (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (pwr_dn),
            .we   (bank_we[k]),
            .widx (widx),
            .wdat (wdat),
            .ridx (comp_in[NCOL-1-k][IDX_W-1:0]),
            .rdat (rd)
        );
        assign comp_lut[NCOL-1-k] = rd;
    end

    always_comb begin
        pipe_d.vld = vld_i;
        pipe_d.en  = en;
        pipe_d.pix = pix_i;
        vld_o      = pipe_q.vld;
        pix_o      = pipe_q.en ? pixel_t'(comp_lut) : pipe_q.pix;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q    <= '0;
            past_ok_q <= 1'b0;
        end else begin
            pipe_q    <= pipe_d;
            past_ok_q <= 1'b1;
        end
    end

    AST_VLD_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q |-> (vld_o == $past(vld_i))); // R8
    AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(vld_i && !en)) |-> (pix_o == $past(pix_i))); // R7
endmodule

// File: rtl/gamma_lut_loader.sv
module gamma_lut_loader
    import gamma_lut_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int LUT_DEPTH = 256
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic                    reg_sel,
    input  logic [REG_W-1:0]        reg_wdata,
    input  logic [NUM_CH-1:0]       gamma_en,
    input  logic [NUM_CH-1:0]       pix_vld_i,
    input  logic [NUM_CH*PIX_W-1:0] pix_i,
    output logic [NUM_CH-1:0]       pix_vld_o,
    output logic [NUM_CH*PIX_W-1:0] pix_o
);
    localparam int TOTAL  = NUM_CH * NCOL * LUT_DEPTH;
    localparam int ADDR_W = $clog2(TOTAL + 1);
    localparam int IDX_W  = $clog2(LUT_DEPTH);
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic                    pwr_dn;
    logic [ADDR_W-1:0]       cur_addr;
    logic                    wr_valid;
    logic [CH_W-1:0]         wr_ch;
    colour_e                 wr_col;
    logic [IDX_W-1:0]        wr_idx;
    logic [ENT_W-1:0]        wr_data;
    logic [NUM_CH-1:0][NCOL-1:0] we_grid;

    assign pwr_dn = ~|gamma_en;

    gamma_addr_ctrl #(
        .NUM_CH(NUM_CH), .LUT_DEPTH(LUT_DEPTH), .TOTAL(TOTAL),
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CH_W(CH_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .pwr_dn    (pwr_dn),
        .cur_addr_o(cur_addr),
        .wr_valid_o(wr_valid),
        .wr_ch_o   (wr_ch),
        .wr_col_o  (wr_col),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pixel_t lane_in, lane_out;
        for (genvar k = 0; k < NCOL; k++) begin : g_we
            assign we_grid[c][k] = wr_valid && (wr_ch == CH_W'(c)) && (wr_col == colour_e'(k));
        end
        assign lane_in = pix_i[c*PIX_W +: PIX_W];
        gamma_lane #(.LUT_DEPTH(LUT_DEPTH), .IDX_W(IDX_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .pwr_dn (pwr_dn),
            .en     (gamma_en[c]),
            .bank_we(we_grid[c]),
            .widx   (wr_idx),
            .wdat   (wr_data),
            .vld_i  (pix_vld_i[c]),
            .pix_i  (lane_in),
            .vld_o  (pix_vld_o[c]),
            .pix_o  (lane_out)
        );
        assign pix_o[c*PIX_W +: PIX_W] = lane_out;
    end

    AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_grid)); // R10
    AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == REG_SEL_DATA && cur_addr >= ADDR_W'(TOTAL)) |-> (we_grid == '0)); // R5
    AST_PWRDN_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |-> (we_grid == '0)); // R9
endmodule

// File: tb/gamma_lut_loader_tb.sv
module gamma_lut_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [2:0]  gamma_en = '0;
    logic [2:0]  pix_vld_i = '0;
    logic [71:0] pix_i = '0;
    logic [2:0]  pix_vld_o;
    logic [71:0] pix_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [7:0]  lut_m [2304];
    logic [11:0] m_addr = '0;
    logic        m_inc = 1'b0;

    logic [23:0] exp_q [3][$];
    string       tag_q [3][$];

    always #5 clk = ~clk;

    gamma_lut_loader u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .gamma_en(gamma_en), .pix_vld_i(pix_vld_i),
        .pix_i(pix_i), .pix_vld_o(pix_vld_o), .pix_o(pix_o)
    );

    task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] expect_pix(input int ch, input logic [23:0] p);
        int base;
        base = ch * 768;
        if (!gamma_en[ch]) return p;
        return {lut_m[base + int'(p[23:16])], lut_m[base + 256 + int'(p[15:8])],
                lut_m[base + 512 + int'(p[7:0])]};
    endfunction

    // monitor: pops the scoreboard whenever an output is valid
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < 3; c++) begin
                if (pix_vld_o[c]) begin
                    if (exp_q[c].size() == 0) begin
                        check(1'b0, "R8 unexpected valid", 72'(c), 72'(0));
                    end else begin
                        logic [23:0] e;
                        string t;
                        e = exp_q[c].pop_front();
                        t = tag_q[c].pop_front();
                        check(pix_o[c*24 +: 24] == e, t, 72'(pix_o[c*24 +: 24]), 72'(e));
                    end
                end
            end
        end
    end

    task automatic reg_write(input logic sel, input logic [15:0] data);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
        if (sel == 1'b0) begin
            m_addr = data[11:0]; m_inc = data[15];
        end else begin
            if (|gamma_en && m_addr < 12'd2304) lut_m[m_addr] = data[7:0];
            if (m_inc) m_addr = m_addr + 12'd1;
        end
    endtask

    task automatic idle(input int n);
        pix_vld_i = '0;
        reg_we = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_pix(input logic [2:0] vm, input logic [23:0] p0, input logic [23:0] p1,
                             input logic [23:0] p2, input string tag);
        logic [23:0] ps [3];
        ps[0] = p0; ps[1] = p1; ps[2] = p2;
        pix_vld_i = vm;
        pix_i = {p2, p1, p0};
        for (int c = 0; c < 3; c++) begin
            if (vm[c]) begin
                exp_q[c].push_back(expect_pix(c, ps[c]));
                tag_q[c].push_back(tag);
            end
        end
        @(negedge clk);
        pix_vld_i = '0;
    endtask

    task automatic set_en(input logic [2:0] e);
        gamma_en = e;
        if (e == 3'b000) for (int i = 0; i < 2304; i++) lut_m[i] = 8'h00;
        idle(2);
    endtask

    initial begin
        for (int i = 0; i < 2304; i++) lut_m[i] = 8'h00;
        repeat (4) @(negedge clk);
        check(pix_vld_o == 3'b000, "R1 valid during reset", 72'(pix_vld_o), 72'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(pix_vld_o == 3'b000, "R1 valid after reset", 72'(pix_vld_o), 72'(0));

        // R1: pointer starts at 0 with no auto-advance
        set_en(3'b111);
        reg_write(1'b1, 16'h005A);
        reg_write(1'b1, 16'h003C);
        idle(1);
        drive_pix(3'b001, 24'h000100, 24'h0, 24'h0, "R1 pointer reset");
        idle(2);

        // R3/R4/R6: identity load of all tables with auto-advance
        reg_write(1'b0, 16'h8000);
        for (int i = 0; i < 2304; i++) reg_write(1'b1, 16'(i % 256));
        idle(1);
        drive_pix(3'b111, 24'h123456, 24'hFF00A5, 24'h7F8081, "R6 identity");
        drive_pix(3'b111, 24'h000000, 24'hFFFFFF, 24'h01FE10, "R6 identity");
        idle(2);

        // R10: inverted ramp into channel 1 green only
        reg_write(1'b0, 16'h8000 | 16'(768 + 256));
        for (int i = 0; i < 256; i++) reg_write(1'b1, 16'(255 - i));
        idle(1);
        drive_pix(3'b111, 24'h203040, 24'h203040, 24'h203040, "R10 isolation");
        drive_pix(3'b010, 24'h0, 24'h11FF00, 24'h0, "R3 green layout");
        idle(2);

        // R4: no auto-advance keeps the pointer
        reg_write(1'b0, 16'h0005);
        reg_write(1'b1, 16'h0011);
        reg_write(1'b1, 16'h0022);
        idle(1);
        drive_pix(3'b001, 24'h050000, 24'h0, 24'h0, "R4 hold overwrite");
        drive_pix(3'b001, 24'h060000, 24'h0, 24'h0, "R4 neighbour kept");
        idle(2);

        // R5: last legal entry, first illegal, and pointer wrap
        reg_write(1'b0, 16'h8000 | 16'd2303);
        reg_write(1'b1, 16'h00AA);
        reg_write(1'b1, 16'h00BB);
        reg_write(1'b0, 16'h8000 | 16'd4095);
        reg_write(1'b1, 16'h00CC);
        reg_write(1'b1, 16'h0077);
        idle(1);
        drive_pix(3'b101, 24'h000000, 24'h0, 24'hFFFFFF, "R5 range and wrap");
        drive_pix(3'b111, 24'hFFFEFD, 24'h010203, 24'hFEFFFE, "R5 no stray write");
        idle(2);

        // R7: channel 2 bypass, others still mapped
        set_en(3'b011);
        drive_pix(3'b111, 24'hA1B2C3, 24'hA1B2C3, 24'hA1B2C3, "R7 bypass");
        set_en(3'b111);
        drive_pix(3'b100, 24'h0, 24'h0, 24'h10FF20, "R7 re-enable keeps table");
        idle(2);

        // R8: back-to-back burst with irregular valids
        for (int i = 0; i < 60; i++) begin
            logic [2:0] vm;
            vm = 3'((i * 5 + 3) % 8);
            drive_pix(vm, {8'(i * 37), 8'(i * 91 + 3), 8'(i * 13 + 200)},
                      {8'(i * 7), 8'(255 - i), 8'(i * 3)},
                      {8'(i), 8'(i * 29), 8'(i * 61 + 9)}, "R8 burst");
        end
        idle(2);

        // R9: power down wipes tables and blocks writes
        set_en(3'b000);
        drive_pix(3'b111, 24'h445566, 24'h778899, 24'hAABBCC, "R9 bypass while off");
        reg_write(1'b0, 16'h8000);
        reg_write(1'b1, 16'h0099);
        idle(1);
        set_en(3'b111);
        drive_pix(3'b111, 24'h000000, 24'h051005, 24'hFFFFFF, "R9 cleared");
        idle(4);

        for (int c = 0; c < 3; c++)
            check(exp_q[c].size() == 0, "R8 missing output", 72'(exp_q[c].size()), 72'(0));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule